// File: doc/BRIEF.md
# Flash Write-Status Responder

This block is the device-side command and status logic of a parallel NOR-style flash, seen through a synchronous bus. It watches single-cycle writes for the unlock-and-command sequences of a byte program and of a full chip erase. When either sequence completes, it starts a modelled internal operation whose length is a parameter in clock cycles.

While that operation runs, reads give a status word instead of array contents. Bit 7 is a polarity flag. It is the inverted bit 7 of the byte being programmed, or 0 during an erase. Bit 6 flips on every read. Host software polls either bit to find out when the operation has ended.

After the busy time, a settling window follows, also a parameter in cycles. During that window bit 7 already shows its final value, but the rest of the word is not yet valid. A small register array, indexed by the low address bits, then returns the programmed byte, or all ones after an erase. Command writes are ignored from the start of an operation until the settling window closes.

Top module: `fsr_flash_status`

## Requirements
- R1: After reset, `busy` is 0, `rd_data` is 0, and every array location reads 8'hFF.
- R2: The program sequence is four writes: 8'hAA at 16'h5555, 8'h55 at 16'h2AAA, 8'hA0 at 16'h5555, then any address and data as the target. `busy` is 1 from the clock edge that accepts the fourth write, and stays 1 for exactly BUSY_CYCLES edges.
- R3: The chip-erase sequence is six writes: 8'hAA at 16'h5555, 8'h55 at 16'h2AAA, 8'h80 at 16'h5555, 8'hAA at 16'h5555, 8'h55 at 16'h2AAA, then 8'h10 at 16'h5555. `busy` is 1 from the edge that accepts the sixth write, and stays 1 for exactly BUSY_CYCLES edges.
- R4: A write that does not match the next expected step of a sequence returns the decoder to idle. No operation starts, and the array is unchanged.
- R5: A read accepted while a program is busy returns bit 7 equal to the inverse of bit 7 of the target data, with bits 5:0 equal to 0.
- R6: A read accepted while an erase is busy returns bit 7 equal to 0, with bits 5:0 equal to 0.
- R7: Bit 6 of reads accepted while busy is 0 for the first such read of an operation and inverts on each following busy read.
- R8: For SETTLE_CYCLES edges after `busy` falls, reads return bit 7 at its final value (the target bit 7 for a program, 1 for an erase), with all other bits 0.
- R9: After the settling window, a read returns the array word at address bits MEM_AW-1:0. A program overwrites the target location with the target data. An erase sets every location to 8'hFF.
- R10: Writes accepted while busy or settling are ignored. A complete command sequence issued in that time starts no new operation and changes no array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| rd_en | input | 1 | Read strobe, one read per high cycle |
| addr | input | ADDR_W | Shared address for reads and writes |
| wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Registered read data, updated on the edge after `rd_en` |
| busy | output | 1 | High while the internal operation runs |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, because the two strobes share one address bus. They also assume that the busy time is at least one cycle. The toggle property assumes that two busy reads on consecutive cycles belong to one operation. This holds because an operation cannot start while busy.

The bench drives only one strobe per cycle. The random part picks target addresses, data, read addresses and the point where a stray command sequence is injected. The injection point is kept inside the busy-plus-settle window, so it never overlaps the start of an operation.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

  localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST     = 8'hAA;
  localparam logic [7:0]  KEY_SECOND    = 8'h55;
  localparam logic [7:0]  OPC_PROGRAM   = 8'hA0;
  localparam logic [7:0]  OPC_ERASE_SET = 8'h80;
  localparam logic [7:0]  OPC_CHIP_ALL  = 8'h10;

  typedef enum logic [2:0] {
    CS_IDLE, CS_KEY1, CS_KEY2, CS_PROG_TGT, CS_ERS3, CS_ERS4, CS_ERS5
  } cmd_state_e;

  // Does one bus write carry the expected address/data pair.
  function automatic logic step_hit(input logic [15:0] a, input logic [7:0] d,
                                    input logic [15:0] ea, input logic [7:0] ed);
    return (a == ea) && (d == ed);
  endfunction

  // Status pair {bit7, bit6} while the operation is running.
  function automatic logic [1:0] running_pair(input logic is_erase, input logic true7,
                                              input logic tog);
    return {(is_erase ? 1'b0 : ~true7), tog};
  endfunction

  // Status pair {bit7, bit6} during the settling window.
  function automatic logic [1:0] settling_pair(input logic is_erase, input logic true7);
    return {(is_erase ? 1'b1 : true7), 1'b0};
  endfunction

endpackage

// File: rtl/fsr_cmd_seq.sv
module fsr_cmd_seq
  import fsr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              start_prog,
  output logic              start_erase
);

  cmd_state_e state_q, state_d;
  logic       wr_ok;
  logic [15:0] a16;
  logic [7:0]  d8;

  assign wr_ok = wr_en && accept;
  assign a16   = addr[15:0];
  assign d8    = wdata[7:0];

  always_comb begin
    state_d     = state_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    if (wr_ok) begin
      state_d = CS_IDLE;
      unique case (state_q)
        CS_IDLE:     if (step_hit(a16, d8, UNLOCK_ADDR_A, KEY_FIRST))  state_d = CS_KEY1;
        CS_KEY1:     if (step_hit(a16, d8, UNLOCK_ADDR_B, KEY_SECOND)) state_d = CS_KEY2;
        CS_KEY2: begin
          if (step_hit(a16, d8, UNLOCK_ADDR_A, OPC_PROGRAM))   state_d = CS_PROG_TGT;
          if (step_hit(a16, d8, UNLOCK_ADDR_A, OPC_ERASE_SET)) state_d = CS_ERS3;
        end
        CS_PROG_TGT: start_prog = 1'b1;
        CS_ERS3:     if (step_hit(a16, d8, UNLOCK_ADDR_A, KEY_FIRST))  state_d = CS_ERS4;
        CS_ERS4:     if (step_hit(a16, d8, UNLOCK_ADDR_B, KEY_SECOND)) state_d = CS_ERS5;
        CS_ERS5:     start_erase = step_hit(a16, d8, UNLOCK_ADDR_A, OPC_CHIP_ALL);
        default:     state_d = CS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/fsr_op_timer.sv
module fsr_op_timer #(
  parameter int BUSY_CYCLES   = 12,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic settling,
  output logic done
);

  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam int SW = $clog2(SETTLE_CYCLES + 2);
  localparam logic [BW-1:0] BUSY_LOAD   = BW'(BUSY_CYCLES);
  localparam logic [SW-1:0] SETTLE_LOAD = SW'(SETTLE_CYCLES);

  logic [BW-1:0] busy_cnt;
  logic [SW-1:0] settle_cnt;

  assign busy     = (busy_cnt != '0);
  assign settling = (settle_cnt != '0);
  assign done     = (busy_cnt == BW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt   <= '0;
      settle_cnt <= '0;
    end else begin
      if (start)     busy_cnt <= BUSY_LOAD;
      else if (busy) busy_cnt <= busy_cnt - BW'(1);
      if (done)          settle_cnt <= SETTLE_LOAD;
      else if (settling) settle_cnt <= settle_cnt - SW'(1);
    end
  end

endmodule

// File: rtl/fsr_status_bits.sv
module fsr_status_bits
  import fsr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_is_erase,
  input  logic       start_true7,
  input  logic       rd_en,
  input  logic       busy,
  output logic       op_erase,
  output logic [1:0] run_pair,
  output logic [1:0] settle_pair
);

  logic true7_q;
  logic tog_q;

  assign run_pair    = running_pair(op_erase, true7_q, tog_q);
  assign settle_pair = settling_pair(op_erase, true7_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_erase <= 1'b0;
      true7_q  <= 1'b0;
      tog_q    <= 1'b0;
    end else if (start) begin
      op_erase <= start_is_erase;
      true7_q  <= start_true7;
      tog_q    <= 1'b0;
    end else if (rd_en && busy) begin
      tog_q <= ~tog_q;
    end
  end

endmodule

// File: rtl/fsr_flash_status.sv
module fsr_flash_status
  import fsr_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int MEM_AW        = 4,
  parameter int BUSY_CYCLES   = 12,
  parameter int SETTLE_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy
);

  localparam int DEPTH = 1 << MEM_AW;

  logic              start_prog, start_erase, start_any;
  logic              settling, done, locked, op_erase;
  logic [1:0]        run_pair, settle_pair;
  logic [MEM_AW-1:0] tgt_idx;
  logic [DATA_W-1:0] tgt_data;
  logic [DATA_W-1:0] mem [DEPTH];

  assign start_any = start_prog || start_erase;
  assign locked    = busy || settling;

  fsr_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .accept(!locked),
    .addr(addr), .wdata(wdata),
    .start_prog(start_prog), .start_erase(start_erase)
  );

  fsr_op_timer #(.BUSY_CYCLES(BUSY_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_any),
    .busy(busy), .settling(settling), .done(done)
  );

  fsr_status_bits u_stat (
    .clk(clk), .rst_n(rst_n), .start(start_any),
    .start_is_erase(start_erase), .start_true7(wdata[7]),
    .rd_en(rd_en), .busy(busy), .op_erase(op_erase),
    .run_pair(run_pair), .settle_pair(settle_pair)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_idx  <= '0;
      tgt_data <= '0;
    end else if (start_prog) begin
      tgt_idx  <= addr[MEM_AW-1:0];
      tgt_data <= wdata;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[gi] <= '1;
      else if (done && op_erase) mem[gi] <= '1;
      else if (done && tgt_idx == MEM_AW'(gi)) mem[gi] <= tgt_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else if (rd_en) begin
      if (busy)          rd_data <= {run_pair, {(DATA_W-2){1'b0}}};
      else if (settling) rd_data <= {settle_pair, {(DATA_W-2){1'b0}}};
      else               rd_data <= mem[addr[MEM_AW-1:0]];
    end
  end

endmodule

// File: rtl/fsr_flash_status_chk.sv
module fsr_flash_status_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              busy,
  input logic              start_any,
  input logic              done,
  input logic              locked,
  input logic              op_erase
);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_any |=> busy);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  no_start_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> !start_any);

  // R6
  erase_dq7_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && op_erase) |=> !rd_data[DATA_W-1]);

  // R5
  status_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && locked) |=> (rd_data[DATA_W-3:0] == '0));

  // R7
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) ##1 (rd_en && busy) |=> (rd_data[DATA_W-2] != $past(rd_data[DATA_W-2])));

endmodule

bind fsr_flash_status fsr_flash_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data), .busy(busy),
  .start_any(start_any), .done(done), .locked(locked), .op_erase(op_erase)
);

// File: tb/test_fsr_flash_status.sv
module test_fsr_flash_status;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int MEM_AW = 4;
  localparam int B = 12;
  localparam int S = 4;
  localparam int DEPTH = 1 << MEM_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic              rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rd_data;
  logic              busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [7:0] ref_mem [DEPTH];

  fsr_flash_status #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW),
                     .BUSY_CYCLES(B), .SETTLE_CYCLES(S)) i_fsr_flash_status (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rd_data(rd_data), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk); #1; rd_en = 1'b0; d = rd_data;
  endtask

  function automatic logic [23:0] erase_step(input int i);
    case (i)
      0: return {16'h5555, 8'hAA};
      1: return {16'h2AAA, 8'h55};
      2: return {16'h5555, 8'h80};
      3: return {16'h5555, 8'hAA};
      4: return {16'h2AAA, 8'h55};
      default: return {16'h5555, 8'h10};
    endcase
  endfunction

  function automatic logic [7:0] exp_busy(input bit er, input logic [7:0] d, input bit tog);
    return {(er ? 1'b0 : ~d[7]), tog, 6'b0};
  endfunction

  function automatic logic [7:0] exp_settle(input bit er, input logic [7:0] d);
    return {(er ? 1'b1 : d[7]), 7'b0};
  endfunction

  task automatic start_prog(input logic [15:0] a, input logic [7:0] d);
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'hA0); wr(a, d);
    chk(busy === 1'b1, "R2 busy after fourth write", busy, 1);
  endtask

  task automatic start_erase();
    for (int i = 0; i < 6; i++) begin
      logic [23:0] st = erase_step(i);
      wr(st[23:8], st[7:0]);
    end
    chk(busy === 1'b1, "R3 busy after sixth write", busy, 1);
  endtask

  // Operation window: step k is the k-th edge after the start edge.
  task automatic window(input bit er, input logic [15:0] ta, input logic [7:0] td,
                        input bit inject, input int k0);
    bit tog = 0;
    for (int k = 1; k <= B + S + 2; k++) begin
      if (k == B + 1) begin
        if (er) for (int j = 0; j < DEPTH; j++) ref_mem[j] = 8'hFF;
        else ref_mem[ta[MEM_AW-1:0]] = td;
      end
      if (inject && k >= k0 && k < k0 + 6) begin
        logic [23:0] st = erase_step(k - k0);
        wr(st[23:8], st[7:0]);
      end else begin
        logic [15:0] ra = 16'($urandom);
        logic [7:0]  got;
        logic [7:0]  exp;
        rd(ra, got);
        if (k <= B) begin
          exp = exp_busy(er, td, tog);
          tog = ~tog;
          chk(got === exp, er ? "R6 R7 busy read" : "R5 R7 busy read", got, exp);
        end else if (k <= B + S) begin
          exp = exp_settle(er, td);
          chk(got === exp, "R8 settle read", got, exp);
        end else begin
          exp = ref_mem[ra[MEM_AW-1:0]];
          chk(got === exp, "R9 array read", got, exp);
        end
      end
      chk(busy === (k < B), er ? "R3 busy length" : "R2 busy length", busy, k < B);
    end
    if (inject) begin
      repeat (B + 2) @(posedge clk);
      #1;
      chk(busy === 1'b0, "R10 no new op", busy, 0);
    end
    begin
      logic [7:0] got;
      rd(ta, got);
      chk(got === ref_mem[ta[MEM_AW-1:0]], "R9 R10 target read", got, ref_mem[ta[MEM_AW-1:0]]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int seed_val;
    seed_val = $urandom(32'h5EED);
    for (int j = 0; j < DEPTH; j++) ref_mem[j] = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk(busy === 1'b0, "R1 busy at reset", busy, 0);
    chk(rd_data === 8'h00, "R1 rd_data at reset", rd_data, 0);
    rst_n = 1'b1;
    for (int j = 0; j < DEPTH; j++) begin
      rd(16'(j), got);
      chk(got === 8'hFF, "R1 erased after reset", got, 8'hFF);
    end

    // R4: bad third step, then a would-be target write
    wr(16'h5555, 8'hAA); wr(16'h2AAA, 8'h55); wr(16'h5555, 8'h33); wr(16'h0003, 8'h12);
    chk(busy === 1'b0, "R4 bad program step", busy, 0);
    rd(16'h0003, got);
    chk(got === 8'hFF, "R4 array untouched", got, 8'hFF);
    // R4: wrong final erase code
    for (int i = 0; i < 5; i++) begin
      logic [23:0] st = erase_step(i);
      wr(st[23:8], st[7:0]);
    end
    wr(16'h5555, 8'h30);
    chk(busy === 1'b0, "R4 bad erase code", busy, 0);
    // R4: wrong second address
    wr(16'h5555, 8'hAA); wr(16'h2AAB, 8'h55); wr(16'h5555, 8'hA0); wr(16'h0004, 8'h00);
    chk(busy === 1'b0, "R4 bad unlock address", busy, 0);

    // Directed: program with bit7 = 1 and bit7 = 0
    start_prog(16'h0025, 8'h80); window(0, 16'h0025, 8'h80, 0, 1);
    start_prog(16'h0036, 8'h3C); window(0, 16'h0036, 8'h3C, 0, 1);
    // R10: erase sequence injected while a program is busy
    start_prog(16'h0047, 8'hA5); window(0, 16'h0047, 8'hA5, 1, 2);
    // Directed erase
    start_erase(); window(1, 16'h0036, 8'h00, 0, 1);

    // Random mix
    for (int it = 0; it < 20; it++) begin
      logic [15:0] ta = 16'($urandom);
      logic [7:0]  td = 8'($urandom);
      bit inj = ($urandom % 3) == 0;
      int k0 = 1 + int'($urandom % (B + S - 5));
      if (($urandom % 6) == 0) begin
        start_erase(); window(1, ta, 8'h00, inj, k0);
      end else begin
        start_prog(ta, td); window(0, ta, td, inj, k0);
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule